// File: doc/BRIEF.md
# Quarter-Pel Luma Block Interpolator

This block forms the motion-compensated prediction of one 4x4 luma block. Reference pixels arrive one vertical column per accepted beat, each column holding nine pixels that span two rows above the block to three rows below it. The fractional parts of the motion vector come with the first column of each block. Predicted pixels leave one 4-pixel column per beat. Integer vectors stream straight through. For fractional vectors, the block keeps a six-column sliding window. That window feeds the vertical and horizontal six-tap filters, a two-sample selector and a rounding average stage.

A block with an integer vector takes four input columns, x = 0..3. A block with any fractional component takes nine input columns, x = -2..6, and its four output columns appear as the sixth to ninth input columns are accepted. Both sides use valid/ready handshakes, so gaps on the input and backpressure on the output are handled without loss.

Top module: `qpel_luma_interp`

## Requirements
- R1: After reset, outValid is low and inReady is high.
- R2: When both fractions are 0, the block takes 4 columns. Each accepted column produces one output column whose pixel r is input pixel r+2. Input pixel i sits at bits [8i+7:8i] and is row y=i-2. Output pixel r sits at bits [8r+7:8r].
- R3: When either fraction is nonzero, the block takes 9 columns, x=-2..6, and the outputs for x=0..3 follow the 6th..9th accepted columns. Half positions (fracX,fracY) = (2,0) and (0,2) use taps 1,-5,20,20,-5,1 with +16, >>5 and a clip to 0..255.
- R4: Position (2,2) applies the horizontal six-tap filter to the unrounded vertical sums, then adds 512, shifts right by 10 and clips.
- R5: Every other fractional position is (a+b+1)>>1 of two full or half samples, following the standard luma quarter-sample table (fracX is horizontal).
- R6: outLast is high only on the 4th output column of a block, and the next block starts cleanly after it.
- R7: While outValid is high and outReady is low, outValid and outCol hold and inReady is low.
- R8: Idle cycles on inValid and stalls on outReady do not change any output value.
- R9: inFracX and inFracY are sampled only with a block's first column. Their values on later columns have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Reference column present |
| inReady | output | 1 | Column accepted this cycle when inValid is high |
| inCol | input | 72 | Nine 8-bit pixels, rows y=-2..6 |
| inFracX | input | 2 | Horizontal quarter fraction (first column only) |
| inFracY | input | 2 | Vertical quarter fraction (first column only) |
| outValid | output | 1 | Predicted column present |
| outReady | input | 1 | Downstream takes the column |
| outCol | output | 32 | Four predicted 8-bit pixels, rows 0..3 |
| outLast | output | 1 | Final column of the block |

## Verification
A stale or misaligned window column shows up as a wrong value in the first output column of a fractional block, one cycle after the sixth column is accepted. The column counter and the latched fractions are checked at every block boundary because outLast and the output count must line up exactly. A wrongly chosen sample pair or a wrong rounding constant gives wrong pixels at a single fractional position. The sweep covers all sixteen positions and includes saturating patterns that exercise the clip bounds. A fault in holding the output under backpressure is caught at the very next stalled cycle.

// File: rtl/qpel_pkg.sv
package qpel_pkg;
  localparam int PIX_W = 8;
  localparam int SUM_W = 22;

  typedef struct packed {
    logic       shift;
    logic       produce;
    logic       intMode;
    logic [1:0] fracX;
    logic [1:0] fracY;
  } strobe_t;

  localparam logic signed [SUM_W-1:0] K5   = SUM_W'(5);
  localparam logic signed [SUM_W-1:0] K20  = SUM_W'(20);
  localparam logic signed [SUM_W-1:0] RND5 = SUM_W'(16);
  localparam logic signed [SUM_W-1:0] RND10 = SUM_W'(512);

  function automatic logic signed [SUM_W-1:0] widen(input logic [PIX_W-1:0] p);
    return {{(SUM_W-PIX_W){1'b0}}, p};
  endfunction

  function automatic logic signed [SUM_W-1:0] tap6(
      input logic signed [SUM_W-1:0] a, input logic signed [SUM_W-1:0] b,
      input logic signed [SUM_W-1:0] c, input logic signed [SUM_W-1:0] d,
      input logic signed [SUM_W-1:0] e, input logic signed [SUM_W-1:0] f);
    return a + f - K5 * (b + e) + K20 * (c + d);
  endfunction

  function automatic logic [PIX_W-1:0] clipPix(input logic signed [SUM_W-1:0] v);
    if (v < 0) return '0;
    else if (v > SUM_W'((1 << PIX_W) - 1)) return '1;
    else return v[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/qpel_ctrl.sv
module qpel_ctrl
  import qpel_pkg::*;
#(
  parameter int BLK = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  input  logic [1:0] inFracX,
  input  logic [1:0] inFracY,
  output logic       outValid,
  input  logic       outReady,
  output logic       outLast,
  output strobe_t    stb
);
  localparam int COL_N = BLK + 5;
  localparam int WIN   = 6;
  localparam int CNT_W = $clog2(COL_N);

  logic [CNT_W-1:0] colCnt;
  logic [1:0]       fxQ, fyQ;
  logic [1:0]       curFx, curFy;
  logic             intMode, accept, produce, atLast;
  logic [CNT_W-1:0] lastIdx;

  always_comb begin
    curFx   = (colCnt == '0) ? inFracX : fxQ;
    curFy   = (colCnt == '0) ? inFracY : fyQ;
    intMode = (curFx == 2'd0) && (curFy == 2'd0);
    lastIdx = intMode ? CNT_W'(BLK - 1) : CNT_W'(COL_N - 1);
    atLast  = (colCnt == lastIdx);
    inReady = !outValid || outReady;
    accept  = inValid && inReady;
    produce = accept && (intMode || (colCnt >= CNT_W'(WIN - 1)));
    stb.shift   = accept;
    stb.produce = produce;
    stb.intMode = intMode;
    stb.fracX   = curFx;
    stb.fracY   = curFy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colCnt   <= '0;
      fxQ      <= '0;
      fyQ      <= '0;
      outValid <= 1'b0;
      outLast  <= 1'b0;
    end else begin
      if (accept) begin
        colCnt <= atLast ? '0 : colCnt + 1'b1;
        if (colCnt == '0) begin
          fxQ <= inFracX;
          fyQ <= inFracY;
        end
      end
      if (produce) begin
        outValid <= 1'b1;
        outLast  <= atLast;
      end else if (outReady) begin
        outValid <= 1'b0;
        outLast  <= 1'b0;
      end
    end
  end

  assert_hold_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid);
  assert_inready_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |-> outValid && !outReady);
  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    colCnt <= CNT_W'(COL_N - 1));
  assert_last_with_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);
  assert_idle_after_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outLast |-> colCnt == '0);
endmodule

// File: rtl/qpel_datapath.sv
module qpel_datapath
  import qpel_pkg::*;
#(
  parameter int BLK = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    stb,
  input  logic [(BLK+5)*PIX_W-1:0]   inCol,
  output logic [BLK*PIX_W-1:0]       outCol
);
  localparam int COL_N  = BLK + 5;
  localparam int FULL_N = BLK + 1;
  localparam int WIN    = 6;

  logic [PIX_W-1:0]        pix   [COL_N];
  logic signed [SUM_W-1:0] vIn   [BLK];
  logic [PIX_W-1:0]        winF  [WIN][FULL_N];
  logic signed [SUM_W-1:0] winV  [WIN][BLK];
  logic [PIX_W-1:0]        wF    [WIN][FULL_N];
  logic signed [SUM_W-1:0] wV    [WIN][BLK];
  logic [PIX_W-1:0]        bHalf [FULL_N];
  logic [PIX_W-1:0]        hHalf [BLK];
  logic [PIX_W-1:0]        mHalf [BLK];
  logic [PIX_W-1:0]        jHalf [BLK];

  for (genvar i = 0; i < COL_N; i++) begin : g_unpack
    assign pix[i] = inCol[i*PIX_W +: PIX_W];
  end

  // vertical six-tap sums of the incoming column, kept unrounded
  for (genvar r = 0; r < BLK; r++) begin : g_vert
    assign vIn[r] = tap6(widen(pix[r]), widen(pix[r+1]), widen(pix[r+2]),
                         widen(pix[r+3]), widen(pix[r+4]), widen(pix[r+5]));
  end

  // window as seen after the incoming column is shifted in
  always_comb begin
    for (int i = 0; i < WIN - 1; i++) begin
      wF[i] = winF[i+1];
      wV[i] = winV[i+1];
    end
    for (int r = 0; r < FULL_N; r++) wF[WIN-1][r] = pix[r+2];
    for (int r = 0; r < BLK; r++)    wV[WIN-1][r] = vIn[r];
  end

  always_ff @(posedge clk) begin
    if (stb.shift) begin
      winF <= wF;
      winV <= wV;
    end
  end

  // horizontal filters: FULL_N on full rows, BLK on vertical sums
  for (genvar r = 0; r < FULL_N; r++) begin : g_hfull
    logic signed [SUM_W-1:0] hSum;
    assign hSum = tap6(widen(wF[0][r]), widen(wF[1][r]), widen(wF[2][r]),
                       widen(wF[3][r]), widen(wF[4][r]), widen(wF[5][r]));
    assign bHalf[r] = clipPix((hSum + RND5) >>> 5);
  end

  for (genvar r = 0; r < BLK; r++) begin : g_hmid
    logic signed [SUM_W-1:0] jSum;
    assign jSum = tap6(wV[0][r], wV[1][r], wV[2][r], wV[3][r], wV[4][r], wV[5][r]);
    assign jHalf[r] = clipPix((jSum + RND10) >>> 10);
    assign hHalf[r] = clipPix((wV[2][r] + RND5) >>> 5);
    assign mHalf[r] = clipPix((wV[3][r] + RND5) >>> 5);
  end

  for (genvar r = 0; r < BLK; r++) begin : g_out
    logic [PIX_W-1:0] selA, selB, gP, hP, mP, bP, sP, jP, fullH, fullM;
    logic [PIX_W:0]   avg;
    always_comb begin
      gP = wF[2][r];   fullH = wF[3][r];   fullM = wF[2][r+1];
      bP = bHalf[r];   sP = bHalf[r+1];
      hP = hHalf[r];   mP = mHalf[r];      jP = jHalf[r];
      case ({stb.fracX, stb.fracY})
        4'b0000: begin selA = wF[WIN-1][r]; selB = wF[WIN-1][r]; end
        4'b0001: begin selA = gP;  selB = hP;    end
        4'b0010: begin selA = hP;  selB = hP;    end
        4'b0011: begin selA = hP;  selB = fullM; end
        4'b0100: begin selA = gP;  selB = bP;    end
        4'b0101: begin selA = bP;  selB = hP;    end
        4'b0110: begin selA = hP;  selB = jP;    end
        4'b0111: begin selA = hP;  selB = sP;    end
        4'b1000: begin selA = bP;  selB = bP;    end
        4'b1001: begin selA = bP;  selB = jP;    end
        4'b1010: begin selA = jP;  selB = jP;    end
        4'b1011: begin selA = jP;  selB = sP;    end
        4'b1100: begin selA = bP;  selB = fullH; end
        4'b1101: begin selA = bP;  selB = mP;    end
        4'b1110: begin selA = jP;  selB = mP;    end
        default: begin selA = sP;  selB = mP;    end
      endcase
      avg = ({1'b0, selA} + {1'b0, selB} + 1'b1) >> 1;
    end
    always_ff @(posedge clk) begin
      if (!rstN) outCol[r*PIX_W +: PIX_W] <= '0;
      else if (stb.produce) outCol[r*PIX_W +: PIX_W] <= avg[PIX_W-1:0];
    end
  end
endmodule

// File: rtl/qpel_luma_interp.sv
module qpel_luma_interp
  import qpel_pkg::*;
#(
  parameter int BLK = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic [(BLK+5)*PIX_W-1:0] inCol,
  input  logic [1:0]               inFracX,
  input  logic [1:0]               inFracY,
  output logic                     outValid,
  input  logic                     outReady,
  output logic [BLK*PIX_W-1:0]     outCol,
  output logic                     outLast
);
  strobe_t stb;

  qpel_ctrl #(.BLK(BLK)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inFracX(inFracX), .inFracY(inFracY), .outValid(outValid),
    .outReady(outReady), .outLast(outLast), .stb(stb)
  );

  qpel_datapath #(.BLK(BLK)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .inCol(inCol), .outCol(outCol)
  );

  assert_stable_data_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outCol));
endmodule

// File: tb/qpel_luma_interp_bench.sv
module qpel_luma_interp_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [71:0] inCol = '0;
  logic [1:0]  inFracX = '0, inFracY = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [31:0] outCol;
  logic        outLast;

  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  qpel_luma_interp u_qpel_luma_interp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inCol(inCol),
    .inFracX(inFracX), .inFracY(inFracY), .outValid(outValid), .outReady(outReady),
    .outCol(outCol), .outLast(outLast)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic int refPix(int x, int y, int pat);
    case (pat)
      0: return ((x * 73 + y * 151 + x * y * 7 + 19) ^ (y * 29)) & 255;
      1: return ((x + y) & 1) ? 255 : 0;
      2: return ((x * 37) ^ (y * 91) ^ (x * y)) & 255;
      default: return ((x >>> 1) & 1) != ((y >>> 1) & 1) ? 252 : 2;
    endcase
  endfunction

  function automatic int clp(int v);
    return v < 0 ? 0 : (v > 255 ? 255 : v);
  endfunction

  function automatic int t6(int a, int b, int c, int d, int e, int f);
    return a - 5 * b + 20 * c + 20 * d - 5 * e + f;
  endfunction

  function automatic int vsum(int x, int y, int p);
    return t6(refPix(x, y-2, p), refPix(x, y-1, p), refPix(x, y, p),
              refPix(x, y+1, p), refPix(x, y+2, p), refPix(x, y+3, p));
  endfunction

  function automatic int bH(int x, int y, int p);
    return clp((t6(refPix(x-2, y, p), refPix(x-1, y, p), refPix(x, y, p),
                   refPix(x+1, y, p), refPix(x+2, y, p), refPix(x+3, y, p)) + 16) >>> 5);
  endfunction

  function automatic int hV(int x, int y, int p);
    return clp((vsum(x, y, p) + 16) >>> 5);
  endfunction

  function automatic int jC(int x, int y, int p);
    return clp((t6(vsum(x-2, y, p), vsum(x-1, y, p), vsum(x, y, p),
                   vsum(x+1, y, p), vsum(x+2, y, p), vsum(x+3, y, p)) + 512) >>> 10);
  endfunction

  function automatic int av(int a, int b);
    return (a + b + 1) >> 1;
  endfunction

  function automatic int expPix(int fx, int fy, int x, int y, int p);
    int g, b, h, j, s, m;
    g = refPix(x, y, p); b = bH(x, y, p); h = hV(x, y, p);
    j = jC(x, y, p); s = bH(x, y+1, p); m = hV(x+1, y, p);
    case (fx * 4 + fy)
      0: return g;
      1: return av(g, h);
      2: return h;
      3: return av(h, refPix(x, y+1, p));
      4: return av(g, b);
      5: return av(b, h);
      6: return av(h, j);
      7: return av(h, s);
      8: return b;
      9: return av(b, j);
      10: return j;
      11: return av(j, s);
      12: return av(b, refPix(x+1, y, p));
      13: return av(b, m);
      14: return av(j, m);
      default: return av(s, m);
    endcase
  endfunction

  task automatic runBlock(int fx, int fy, int pat, int bx, int by, bit stall);
    int nCols, sent, got, holdOk;
    logic [31:0] expCol, heldCol;
    string tag;
    bit frac;
    frac = (fx != 0) || (fy != 0);
    nCols = frac ? 9 : 4;
    if (!frac) tag = "R2";
    else if ((fx == 2 && fy == 0) || (fx == 0 && fy == 2)) tag = "R3";
    else if (fx == 2 && fy == 2) tag = "R4";
    else tag = "R5";
    tag = {tag, stall ? "/R8/R9" : "/R9"};
    sent = 0; got = 0; holdOk = 0; heldCol = '0;
    while (got < 4) begin
      @(negedge clk);
      inValid = (sent < nCols) && !(stall && (cyc % 3 == 1));
      outReady = !(stall && (cyc % 5 >= 3));
      for (int i = 0; i < 9; i++)
        inCol[i*8 +: 8] = 8'(refPix(bx + sent - (frac ? 2 : 0), by + i - 2, pat));
      inFracX = (sent == 0) ? 2'(fx) : 2'(~fx);
      inFracY = (sent == 0) ? 2'(fy) : 2'(fy + 1);
      #1;
      if (holdOk) begin
        checks++;
        if (!outValid || outCol !== heldCol) begin
          fails++;
          $display("FAIL R7 hold: actual valid=%0b col=%h expected valid=1 col=%h",
                   outValid, outCol, heldCol);
        end
      end
      holdOk = 0;
      if (outValid && !outReady) begin
        checks++;
        if (inReady !== 1'b0) begin
          fails++;
          $display("FAIL R7 inReady: actual=%0b expected=0", inReady);
        end
        holdOk = 1; heldCol = outCol;
      end
      if (outValid && outReady) begin
        for (int r = 0; r < 4; r++)
          expCol[r*8 +: 8] = 8'(expPix(fx, fy, bx + got, by + r, pat));
        checks++;
        if (outCol !== expCol) begin
          fails++;
          $display("FAIL %s frac=(%0d,%0d) pat=%0d col=%0d: actual=%h expected=%h",
                   tag, fx, fy, pat, got, outCol, expCol);
        end
        checks++;
        if (outLast !== (got == 3)) begin
          fails++;
          $display("FAIL R6 outLast col=%0d: actual=%0b expected=%0b", got, outLast, got == 3);
        end
        got++;
      end
      if (inValid && inReady) sent++;
    end
    @(negedge clk);
    inValid = 1'b0;
    outReady = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (outValid !== 1'b0 || inReady !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset: actual valid=%0b ready=%0b expected valid=0 ready=1",
               outValid, inReady);
    end
    @(negedge clk);
    rstN = 1'b1;
    for (int pat = 0; pat < 4; pat++)
      for (int fx = 0; fx < 4; fx++)
        for (int fy = 0; fy < 4; fy++)
          runBlock(fx, fy, pat, fx * 4 + pat * 3, fy * 4 + pat, pat >= 2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule